// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block keeps a DRAM array alive by issuing CAS-before-RAS refresh cycles at a programmable rate. A down-counter reloaded from the period input produces one refresh tick per interval. Each tick is added to a small pending counter. The scheduler raises a request to the memory arbiter whenever refreshes are owed. Each grant it accepts launches one refresh strobe sequence: CAS goes low first, then RAS joins it, then both return high for a precharge gap. Ticks that arrive while the bus is busy are not lost. Up to seven of them are held and later served back to back. A sticky flag reports any tick that arrived when the counter was already full.

There are two reset inputs. The power-on reset clears the whole block. The external reset input only clears the overflow flag, so ticking, requesting and strobing all carry on while it is held. Clearing the enable stops the timer, discards every owed refresh and drops the request. A strobe sequence that has already begun still runs to its end.

Top module: `rfsh_sched`

## Requirements
- R1: While `rst_n` is low and in the cycle after it rises, `ras_n` and `cas_n` are 1 and `req` and `ovf` are 0.
- R2: With `en` high, a refresh falls due every `period` clocks. The first one is due `period` clocks after the first edge that sees `en`. A `period` of 0 behaves as 1.
- R3: `req` is high exactly while at least one refresh is owed. Every grant accepted while the sequencer is idle removes one owed refresh.
- R4: A grant sampled with `req` high drives `cas_n` low on the next cycle. `cas_n` stays low alone for `cas_lead` cycles, then `ras_n` and `cas_n` are both low for `ras_width` cycles. A value of 0 in either field counts as 1, and `ras_n` is never low while `cas_n` is high.
- R5: After each strobe sequence, `ras_n` and `cas_n` rise together and stay high for `PRECH_CYC` cycles plus the idle cycle in which the next grant is taken.
- R6: Up to `PEND_MAX` (7) owed refreshes are held. With the grant held high they are all served back to back.
- R7: A tick that arrives while `PEND_MAX` refreshes are owed and no grant is taken is dropped and sets `ovf`. `ovf` stays set until `ext_rst` or `rst_n` clears it, and `ext_rst` clears it on the next edge.
- R8: Holding `ext_rst` high changes neither the tick timing, `req`, nor the strobe timing.
- R9: When `en` is low no ticks are made and the owed count is cleared, so `req` is 0 from the next cycle on. A sequence already running still completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst | input | 1 | External reset; clears only the overflow flag |
| en | input | 1 | Refresh enable |
| period | input | CNT_W | Refresh interval in clocks (0 acts as 1) |
| cas_lead | input | TIM_W | Clocks CAS leads RAS (0 acts as 1) |
| ras_width | input | TIM_W | Clocks RAS is held low (0 acts as 1) |
| gnt | input | 1 | Arbiter grant |
| req | output | 1 | Refresh request to the arbiter |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| ovf | output | 1 | Sticky overflow of the owed-refresh counter |

## Verification
The bench runs up to the exact cycle where the eighth unserved tick lands. A counter that wrapped past seven would leave `ovf` low there, and one that saturated one step early would raise it a cycle too soon. It then drains the stack under a held grant, counting exactly seven CAS falls and finding the request low in the cycle of the last grant. This catches a count that is off by one, and catches a sequencer that skips or repeats the precharge gap. Zero values for period, lead and width are run through the table, where a design that failed to clamp them would wrap a timer to its maximum. Clearing the enable during a strobe checks both that the request drops at once and that the DRAM is not left with RAS cut short.

// File: rtl/rfsh_pkg.sv
`timescale 1ns/1ps
package rfsh_pkg;

   // Strobe sequencer phases
   typedef enum logic [1:0] {
      RS_IDLE   = 2'd0,
      RS_LEAD   = 2'd1,
      RS_STROBE = 2'd2,
      RS_PRECH  = 2'd3
   } rfsh_st_e;

endpackage

// File: rtl/rfsh_tick.sv
`timescale 1ns/1ps
// Interval timer: one tick per programmed period while enabled.
module rfsh_tick #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [CNT_W-1:0] period,
   output logic             tick
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] reload;

   // a zero period behaves as one
   assign reload = (period == '0) ? '0 : period - 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!en || cnt_q == '0)
         cnt_q <= reload;
      else
         cnt_q <= cnt_q - 1'b1;
   end

   assign tick = en && (cnt_q == '0);

endmodule

// File: rtl/rfsh_stack.sv
`timescale 1ns/1ps
// Owed-refresh counter with saturation and sticky overflow.
module rfsh_stack #(
   parameter int PEND_MAX = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic ext_rst,
   input  logic tick,
   input  logic take,
   output logic pend_nz,
   output logic ovf
);

   localparam int PEND_W = $clog2(PEND_MAX + 1);
   localparam logic [PEND_W-1:0] FULL = PEND_W'(PEND_MAX);

   logic [PEND_W-1:0] pend_q;
   logic              full;
   logic              drop;

   assign full = (pend_q == FULL);
   assign drop = en && tick && !take && full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
      end else if (!en) begin
         pend_q <= '0;
      end else if (tick && !take) begin
         if (!full)
            pend_q <= pend_q + 1'b1;
      end else if (!tick && take) begin
         pend_q <= pend_q - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ovf <= 1'b0;
      else if (ext_rst)
         ovf <= 1'b0;
      else if (drop)
         ovf <= 1'b1;
   end

   assign pend_nz = (pend_q != '0);

endmodule

// File: rtl/rfsh_seq.sv
`timescale 1ns/1ps
// CAS-before-RAS strobe sequencer.
module rfsh_seq
   import rfsh_pkg::*;
#(
   parameter int TIM_W     = 4,
   parameter int PRECH_CYC = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pend_nz,
   input  logic             gnt,
   input  logic [TIM_W-1:0] cas_lead,
   input  logic [TIM_W-1:0] ras_width,
   output logic             take,
   output logic             cas_act,
   output logic             ras_act
);

   localparam logic [TIM_W-1:0] PRE_LD = TIM_W'(PRECH_CYC - 1);

   rfsh_st_e         st_q;
   logic [TIM_W-1:0] tmr_q;
   logic [TIM_W-1:0] lead_ld;
   logic [TIM_W-1:0] width_ld;

   assign lead_ld  = (cas_lead  == '0) ? '0 : cas_lead  - 1'b1;
   assign width_ld = (ras_width == '0) ? '0 : ras_width - 1'b1;

   assign take = (st_q == RS_IDLE) && pend_nz && gnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= RS_IDLE;
         tmr_q <= '0;
      end else begin
         unique case (st_q)
            RS_IDLE: begin
               if (take) begin
                  st_q  <= RS_LEAD;
                  tmr_q <= lead_ld;
               end
            end
            RS_LEAD: begin
               if (tmr_q == '0) begin
                  st_q  <= RS_STROBE;
                  tmr_q <= width_ld;
               end else begin
                  tmr_q <= tmr_q - 1'b1;
               end
            end
            RS_STROBE: begin
               if (tmr_q == '0) begin
                  st_q  <= RS_PRECH;
                  tmr_q <= PRE_LD;
               end else begin
                  tmr_q <= tmr_q - 1'b1;
               end
            end
            RS_PRECH: begin
               if (tmr_q == '0)
                  st_q <= RS_IDLE;
               else
                  tmr_q <= tmr_q - 1'b1;
            end
            default: st_q <= RS_IDLE;
         endcase
      end
   end

   assign cas_act = (st_q == RS_LEAD) || (st_q == RS_STROBE);
   assign ras_act = (st_q == RS_STROBE);

endmodule

// File: rtl/rfsh_sched.sv
`timescale 1ns/1ps
// Refresh scheduler top: timer, owed-refresh stack, strobe sequencer.
module rfsh_sched #(
   parameter int CNT_W     = 16,
   parameter int TIM_W     = 4,
   parameter int PEND_MAX  = 7,
   parameter int PRECH_CYC = 1,
   parameter int REG_OUT   = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ext_rst,
   input  logic             en,
   input  logic [CNT_W-1:0] period,
   input  logic [TIM_W-1:0] cas_lead,
   input  logic [TIM_W-1:0] ras_width,
   input  logic             gnt,
   output logic             req,
   output logic             ras_n,
   output logic             cas_n,
   output logic             ovf
);

   localparam int PRE_MAX = 1 << TIM_W;

   // elaboration-time parameter checks
   if (CNT_W < 1) begin : g_bad_cnt
      $error("rfsh_sched: CNT_W must be at least 1");
   end
   if (TIM_W < 1) begin : g_bad_tim
      $error("rfsh_sched: TIM_W must be at least 1");
   end
   if (PEND_MAX < 1) begin : g_bad_pend
      $error("rfsh_sched: PEND_MAX must be at least 1");
   end
   if (PRECH_CYC < 1 || PRECH_CYC > PRE_MAX) begin : g_bad_pre
      $error("rfsh_sched: PRECH_CYC out of range");
   end

   logic tick;
   logic take;
   logic pend_nz;
   logic cas_act;
   logic ras_act;

   rfsh_tick #(.CNT_W(CNT_W)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (en),
      .period (period),
      .tick   (tick)
   );

   rfsh_stack #(.PEND_MAX(PEND_MAX)) u_stack (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (en),
      .ext_rst (ext_rst),
      .tick    (tick),
      .take    (take),
      .pend_nz (pend_nz),
      .ovf     (ovf)
   );

   rfsh_seq #(.TIM_W(TIM_W), .PRECH_CYC(PRECH_CYC)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .pend_nz   (pend_nz),
      .gnt       (gnt),
      .cas_lead  (cas_lead),
      .ras_width (ras_width),
      .take      (take),
      .cas_act   (cas_act),
      .ras_act   (ras_act)
   );

   assign req = pend_nz;

   // strobe output stage: registered or decoded straight from state
   if (REG_OUT != 0) begin : g_reg_out
      logic ras_q;
      logic cas_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ras_q <= 1'b1;
            cas_q <= 1'b1;
         end else begin
            ras_q <= !ras_act;
            cas_q <= !cas_act;
         end
      end
      assign ras_n = ras_q;
      assign cas_n = cas_q;
   end else begin : g_comb_out
      assign ras_n = !ras_act;
      assign cas_n = !cas_act;
   end

endmodule

// File: rtl/rfsh_chk.sv
`timescale 1ns/1ps
// Port-level protocol checker for rfsh_sched.
module rfsh_chk (
   input logic clk,
   input logic rst_n,
   input logic ext_rst,
   input logic en,
   input logic req,
   input logic ras_n,
   input logic cas_n,
   input logic ovf
);

   AST_CAS_LEADS_RAS: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_n) |-> (!cas_n && !$past(cas_n)));                       // R4

   AST_RAS_INSIDE_CAS: assert property (@(posedge clk) disable iff (!rst_n)
      !ras_n |-> !cas_n);                                                 // R4

   AST_PRECHARGE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ras_n) |=> (ras_n && cas_n));                                 // R5

   AST_NO_REQ_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !req);                                                      // R9

   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !ext_rst) |=> ovf);                                         // R7

   AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      ext_rst |=> !ovf);                                                  // R7

endmodule

bind rfsh_sched rfsh_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .ext_rst (ext_rst),
   .en      (en),
   .req     (req),
   .ras_n   (ras_n),
   .cas_n   (cas_n),
   .ovf     (ovf)
);

// File: tb/rfsh_sched_bench.sv
`timescale 1ns/1ps
module rfsh_sched_bench;

   localparam int CNT_W = 16;
   localparam int TIM_W = 4;

   typedef struct packed {
      logic [15:0] per;
      logic [3:0]  lead;
      logic [3:0]  wid;
   } vec_t;

   // period, CAS lead, RAS width (zeros act as one)
   localparam vec_t VECS [5] = '{
      '{16'd3, 4'd1, 4'd1},
      '{16'd5, 4'd2, 4'd3},
      '{16'd0, 4'd0, 4'd0},
      '{16'd8, 4'd4, 4'd2},
      '{16'd2, 4'd3, 4'd0}
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             ext_rst = 1'b0;
   logic             en = 1'b0;
   logic [CNT_W-1:0] period = '0;
   logic [TIM_W-1:0] cas_lead = '0;
   logic [TIM_W-1:0] ras_width = '0;
   logic             gnt = 1'b0;
   logic             req;
   logic             ras_n;
   logic             cas_n;
   logic             ovf;

   int n_chk = 0;
   int n_fail = 0;
   int s = 0;

   always #2.5 clk = ~clk;

   rfsh_sched u_rfsh_sched (
      .clk       (clk),
      .rst_n     (rst_n),
      .ext_rst   (ext_rst),
      .en        (en),
      .period    (period),
      .cas_lead  (cas_lead),
      .ras_width (ras_width),
      .gnt       (gnt),
      .req       (req),
      .ras_n     (ras_n),
      .cas_n     (cas_n),
      .ovf       (ovf)
   );

   task automatic step();
      @(posedge clk);
      @(negedge clk);
      s++;
   endtask

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; en = 1'b0; gnt = 1'b0; ext_rst = 1'b0;
      step();
      step();
      rst_n = 1'b1;
      step();
      s = 0;
   endtask

   function automatic int at_least_one(input int v);
      return (v == 0) ? 1 : v;
   endfunction

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : main
      int pe, le, we, fc, fr, cl, rl, falls;
      logic prev_cas;

      // R1: reset state
      step();
      check("R1 ras_n in reset", int'(ras_n), 1);
      check("R1 cas_n in reset", int'(cas_n), 1);
      do_reset();
      check("R1 req after reset", int'(req), 0);
      check("R1 ovf after reset", int'(ovf), 0);

      // table walk: R2 and R4 timing
      for (int i = 0; i < 5; i++) begin
         period    = VECS[i].per;
         cas_lead  = VECS[i].lead;
         ras_width = VECS[i].wid;
         do_reset();
         pe = at_least_one(int'(VECS[i].per));
         le = at_least_one(int'(VECS[i].lead));
         we = at_least_one(int'(VECS[i].wid));
         en = 1'b1; gnt = 1'b1;
         fc = -1; fr = -1; cl = 0; rl = 0;
         while (s < pe + le + we + 2) begin
            step();
            if (!cas_n) begin cl++; if (fc < 0) fc = s; end
            if (!ras_n) begin rl++; if (fr < 0) fr = s; end
         end
         check("R2 first CAS low cycle", fc, pe + 1);
         check("R4 first RAS low cycle", fr, pe + 1 + le);
         check("R4 CAS low length", cl, le + we);
         check("R4 RAS low length", rl, we);
      end

      // R9: disable clears owed refreshes; running sequence completes
      period = 16'd3; cas_lead = 4'd1; ras_width = 4'd1;
      do_reset();
      en = 1'b1;
      while (s < 10) begin
         step();
         if (!cas_n) check("R3 no strobe without grant", 0, 1);
      end
      check("R3 req with owed refreshes", int'(req), 1);
      en = 1'b0;
      step();
      check("R9 req drops after disable", int'(req), 0);
      gnt = 1'b1;
      cl = 0;
      repeat (20) begin
         step();
         if (!cas_n) cl++;
      end
      check("R9 no strobes while disabled", cl, 0);

      cas_lead = 4'd2; ras_width = 4'd2;
      do_reset();
      en = 1'b1; gnt = 1'b1;
      while (s < 4) step();
      check("R4 CAS low at start", int'(cas_n), 0);
      en = 1'b0;
      while (s < 6) step();
      check("R9 RAS still strobes after disable", int'(ras_n), 0);

      // R8: external reset held leaves timing unchanged
      period = 16'd5;
      do_reset();
      ext_rst = 1'b1; en = 1'b1; gnt = 1'b1;
      fc = -1; fr = -1;
      while (s < 10) begin
         step();
         if (!cas_n && fc < 0) fc = s;
         if (!ras_n && fr < 0) fr = s;
      end
      check("R8 CAS timing under ext_rst", fc, 6);
      check("R8 RAS timing under ext_rst", fr, 8);
      ext_rst = 1'b0;

      // R6 / R7: stacking, overflow, back-to-back drain
      period = 16'd40; cas_lead = 4'd1; ras_width = 4'd1;
      do_reset();
      en = 1'b1;
      while (s < 319) step();
      check("R6 req with stack full", int'(req), 1);
      check("R7 ovf before eighth tick", int'(ovf), 0);
      step();
      check("R7 ovf at eighth tick", int'(ovf), 1);
      while (s < 322) step();
      gnt = 1'b1;
      prev_cas = cas_n;
      falls = 0;
      while (s < 355) begin
         step();
         if (prev_cas && !cas_n) falls++;
         prev_cas = cas_n;
         if (s == 325) check("R5 precharge cycle 1", int'(cas_n && ras_n), 1);
         if (s == 326) check("R5 idle cycle before next", int'(cas_n && ras_n), 1);
         if (s == 327) check("R5 next CAS after gap", int'(cas_n), 0);
         if (s == 346) check("R3 req with one owed", int'(req), 1);
         if (s == 347) check("R3 req after last grant", int'(req), 0);
      end
      check("R6 refreshes drained", falls, 7);
      check("R7 ovf sticky", int'(ovf), 1);
      ext_rst = 1'b1;
      step();
      check("R7 ovf cleared by ext_rst", int'(ovf), 0);
      ext_rst = 1'b0;

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule